// File: doc/BRIEF.md
# Nibble-Port Program Memory Programming Interface

This block is the device-side logic that takes over an embedded program memory while programming voltage is present. It watches two high-voltage sense flags, one for the programming supply and one for the core supply, and a 4-bit mode code. The code selects one of four operations: clear the internal address, write a byte, verify (read back) a byte, or inhibit. The byte address is never taken from pins. It is cleared by a mode code and then stepped by one after every fourth rising edge on a single step pin.

Each byte crosses two 4-bit ports. The low port carries bits 3:0 and the high port carries bits 7:4. Each port has separate in, out and output-enable signals, so the pad ring can build bidirectional pins from them. In verify mode both ports drive the byte stored at the current address. In every other mode they float. On entry to write mode the byte on the ports is latched and held. A write strobe then goes to the memory for as long as write mode is held.

The memory side is a plain synchronous strobe with no back-pressure. The memory must accept a write in any cycle where the strobe is high, and it must return read data combinationally from the address. All pin inputs pass through one register stage before use.

Top module: `nibble_prom_prog`

## Requirements
- R1: Programming is active only while hv_prog and hv_core are both 1. While either flag is 0: both output enables and the write strobe stay 0, step-pin edges do not move the address, and the clear code does not clear it.
- R2: Mode code 4'b0101 (mode_pins[0]=1, [1]=0, [2]=1, [3]=0) sets the address to 0 and also clears the step-pulse counter. After a clear, exactly four rising edges are needed to reach address 1.
- R3: In any active mode other than clear, the address increments by one on every fourth rising edge of step_pin. The first three edges of each group leave it unchanged.
- R4: Mode code 4'b1100 (verify) sets lo_oe and hi_oe to 1 together. lo_out carries bits 3:0 and hi_out carries bits 7:4 of the memory byte at the current address.
- R5: Mode code 4'b1110 (write) latches {hi_in, lo_in} into mem_wdata on entry to the mode. mem_wdata is held while the mode stays. mem_we is 1 exactly while write mode is held.
- R6: Codes 4'b1101 and 4'b1111 are inhibit (mode_pins[1] is don't-care). Both ports float and mem_we is 0.
- R7: Any code other than 4'b0101, 4'b1110, 4'b1100, 4'b1101 and 4'b1111 behaves as inhibit: the ports float, there is no strobe, and step edges still count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hv_prog | input | 1 | Programming supply high-voltage flag |
| hv_core | input | 1 | Core supply high-voltage flag |
| mode_pins | input | 4 | Mode code, bit n is mode pin n |
| step_pin | input | 1 | Address step pulse pin |
| lo_in | input | 4 | Low data nibble from pins |
| lo_out | output | 4 | Low data nibble to pins |
| lo_oe | output | 1 | Low port output enable |
| hi_in | input | 4 | High data nibble from pins |
| hi_out | output | 4 | High data nibble to pins |
| hi_oe | output | 1 | High port output enable |
| mem_addr | output | 15 | Program memory byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe |
| mem_rdata | input | 8 | Byte read at mem_addr |

## Verification
Each pin change is captured on edge e. The address, output enables, write strobe and latched write byte change on edge e+1. The driven read byte follows on edge e+2, because it is registered from the memory at the new address. The bench drives pins at the falling edge and waits four full cycles before sampling at a falling edge, so every result is due before its check. The checker properties look two cycles into the past of the pins for the enables and the strobe, which is exactly the register depth between them.

// File: rtl/prog_if_pkg.sv
package prog_if_pkg;
  typedef enum logic [2:0] {
    PM_OFF,
    PM_CLEAR,
    PM_WRITE,
    PM_VERIFY,
    PM_INHIBIT
  } prog_mode_e;

  localparam logic [3:0] CODE_CLEAR  = 4'b0101;
  localparam logic [3:0] CODE_WRITE  = 4'b1110;
  localparam logic [3:0] CODE_VERIFY = 4'b1100;
endpackage

// File: rtl/prog_mode_decode.sv
module prog_mode_decode
  import prog_if_pkg::*;
(
  input  logic       hv_ok,
  input  logic [3:0] code,
  output prog_mode_e mode
);
  always_comb begin
    if (!hv_ok) begin
      mode = PM_OFF;
    end else begin
      unique case (code)
        CODE_CLEAR:  mode = PM_CLEAR;
        CODE_WRITE:  mode = PM_WRITE;
        CODE_VERIFY: mode = PM_VERIFY;
        default:     mode = PM_INHIBIT;  // listed inhibit and unlisted codes
      endcase
    end
  end
endmodule

// File: rtl/prog_addr_stepper.sv
module prog_addr_stepper
  import prog_if_pkg::*;
#(
  parameter int DEPTH = 32640,
  parameter int PULSES_PER_STEP = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = (PULSES_PER_STEP > 1) ? $clog2(PULSES_PER_STEP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  prog_mode_e    mode,
  input  logic          pulse_rise,
  output logic [AW-1:0] addr
);
  localparam logic [CW-1:0] CNT_LAST  = CW'(PULSES_PER_STEP - 1);
  localparam logic [AW-1:0] ADDR_LAST = AW'(DEPTH - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      addr <= '0;
    end else if (mode == PM_CLEAR) begin
      cnt  <= '0;
      addr <= '0;
    end else if (mode != PM_OFF && pulse_rise) begin
      if (cnt == CNT_LAST) begin
        cnt  <= '0;
        addr <= (addr == ADDR_LAST) ? '0 : addr + AW'(1);
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/prog_byte_lanes.sv
module prog_byte_lanes
  import prog_if_pkg::*;
#(
  parameter int LANES = 2,
  parameter int NIB_W = 4,
  localparam int BW = LANES * NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  prog_mode_e       mode,
  input  logic [BW-1:0]    din,
  input  logic [BW-1:0]    rdata,
  output logic [BW-1:0]    wdata,
  output logic [BW-1:0]    dout,
  output logic             we,
  output logic [LANES-1:0] oe
);
  logic entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we <= 1'b0;
    else        we <= (mode == PM_WRITE);
  end

  assign entry = (mode == PM_WRITE) && !we;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [NIB_W-1:0] w_q;
    logic [NIB_W-1:0] d_q;
    logic             o_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        w_q <= '0;
        d_q <= '0;
        o_q <= 1'b0;
      end else begin
        if (entry) w_q <= din[g*NIB_W +: NIB_W];
        d_q <= rdata[g*NIB_W +: NIB_W];
        o_q <= (mode == PM_VERIFY);
      end
    end

    assign wdata[g*NIB_W +: NIB_W] = w_q;
    assign dout[g*NIB_W +: NIB_W]  = d_q;
    assign oe[g]                   = o_q;
  end
endmodule

// File: rtl/nibble_prom_prog.sv
module nibble_prom_prog
  import prog_if_pkg::*;
#(
  parameter int DEPTH = 32640,
  parameter int PULSES_PER_STEP = 4,
  parameter int NIB_W = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int BW = 2 * NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hv_prog,
  input  logic             hv_core,
  input  logic [3:0]       mode_pins,
  input  logic             step_pin,
  input  logic [NIB_W-1:0] lo_in,
  output logic [NIB_W-1:0] lo_out,
  output logic             lo_oe,
  input  logic [NIB_W-1:0] hi_in,
  output logic [NIB_W-1:0] hi_out,
  output logic             hi_oe,
  output logic [AW-1:0]    mem_addr,
  output logic [BW-1:0]    mem_wdata,
  output logic             mem_we,
  input  logic [BW-1:0]    mem_rdata
);
  logic          hv_q;
  logic [3:0]    code_q;
  logic          step_q, step_q2;
  logic [BW-1:0] din_q;
  prog_mode_e    mode;
  logic [BW-1:0] dout;
  logic [1:0]    oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q    <= 1'b0;
      code_q  <= '0;
      step_q  <= 1'b0;
      step_q2 <= 1'b0;
      din_q   <= '0;
    end else begin
      hv_q    <= hv_prog & hv_core;
      code_q  <= mode_pins;
      step_q  <= step_pin;
      step_q2 <= step_q;
      din_q   <= {hi_in, lo_in};
    end
  end

  prog_mode_decode u_dec (
    .hv_ok (hv_q),
    .code  (code_q),
    .mode  (mode)
  );

  prog_addr_stepper #(
    .DEPTH           (DEPTH),
    .PULSES_PER_STEP (PULSES_PER_STEP)
  ) u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .pulse_rise (step_q & ~step_q2),
    .addr       (mem_addr)
  );

  prog_byte_lanes #(
    .LANES (2),
    .NIB_W (NIB_W)
  ) u_lanes (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .din   (din_q),
    .rdata (mem_rdata),
    .wdata (mem_wdata),
    .dout  (dout),
    .we    (mem_we),
    .oe    (oe)
  );

  assign lo_out = dout[NIB_W-1:0];
  assign hi_out = dout[BW-1:NIB_W];
  assign lo_oe  = oe[0];
  assign hi_oe  = oe[1];
endmodule

// File: rtl/prog_if_checker.sv
module prog_if_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        hv_prog,
  input logic        hv_core,
  input logic [3:0]  mode_pins,
  input logic        lo_oe,
  input logic        hi_oe,
  input logic [14:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic        mem_we
);
  logic hv_ok, is_verify, is_write, is_clear, is_inhibit, is_unlisted;
  assign hv_ok       = hv_prog && hv_core;
  assign is_verify   = hv_ok && (mode_pins == 4'b1100);
  assign is_write    = hv_ok && (mode_pins == 4'b1110);
  assign is_clear    = hv_ok && (mode_pins == 4'b0101);
  assign is_inhibit  = hv_ok && mode_pins[3] && mode_pins[2] && mode_pins[0];
  assign is_unlisted = hv_ok && !(mode_pins == 4'b0101 || mode_pins == 4'b1110 ||
                                  mode_pins == 4'b1100 || mode_pins == 4'b1101 ||
                                  mode_pins == 4'b1111);

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hv_ok, 2) |-> (!lo_oe && !hi_oe && !mem_we));

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_clear, 2) |-> (mem_addr == 15'd0));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> (mem_addr == $past(mem_addr) + 15'd1 || mem_addr == 15'd0));

  p_drive_verify_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lo_oe |-> $past(is_verify, 2));

  p_lanes_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lo_oe == hi_oe);

  p_strobe_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(is_write, 2));

  p_wdata_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> $stable(mem_wdata));

  p_inhibit_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_inhibit, 2) |-> (!lo_oe && !mem_we));

  p_unlisted_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_unlisted, 2) |-> (!lo_oe && !mem_we));
endmodule

bind nibble_prom_prog prog_if_checker u_prog_if_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .hv_prog   (hv_prog),
  .hv_core   (hv_core),
  .mode_pins (mode_pins),
  .lo_oe     (lo_oe),
  .hi_oe     (hi_oe),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_we    (mem_we)
);

// File: tb/tb_nibble_prom_prog.sv
`timescale 1ns/1ps
module tb_nibble_prom_prog;
  localparam int DEPTH = 32640;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hv_prog = 1'b0, hv_core = 1'b0;
  logic [3:0]  mode_pins = 4'b1101;
  logic        step_pin = 1'b0;
  logic [3:0]  lo_in = '0, hi_in = '0;
  logic [3:0]  lo_out, hi_out;
  logic        lo_oe, hi_oe, mem_we;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int exp_addr = 0, exp_cnt = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'hA5;
  endfunction

  assign mem_rdata = mem_byte(mem_addr);

  nibble_prom_prog dut (
    .clk(clk), .rst_n(rst_n), .hv_prog(hv_prog), .hv_core(hv_core),
    .mode_pins(mode_pins), .step_pin(step_pin),
    .lo_in(lo_in), .lo_out(lo_out), .lo_oe(lo_oe),
    .hi_in(hi_in), .hi_out(hi_out), .hi_oe(hi_oe),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit active();
    return hv_prog && hv_core;
  endfunction

  task automatic set_mode(input logic [3:0] code);
    @(negedge clk);
    mode_pins = code;
    if (active() && code == 4'b0101) begin
      exp_addr = 0;
      exp_cnt = 0;
    end
    settle(4);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); step_pin = 1'b1;
      @(negedge clk); step_pin = 1'b0;
      if (active() && mode_pins != 4'b0101) begin
        exp_cnt++;
        if (exp_cnt == 4) begin
          exp_cnt = 0;
          exp_addr = (exp_addr == DEPTH - 1) ? 0 : exp_addr + 1;
        end
      end
    end
    settle(4);
  endtask

  task automatic check_verify(input string req);
    logic [7:0] e;
    e = mem_byte(15'(exp_addr));
    chk(req, "address", 32'(mem_addr), 32'(exp_addr));
    chk(req, "lo_oe", 32'(lo_oe), 1);
    chk(req, "hi_oe", 32'(hi_oe), 1);
    chk(req, "lo_out", 32'(lo_out), 32'(e[3:0]));
    chk(req, "hi_out", 32'(hi_out), 32'(e[7:4]));
  endtask

  task automatic check_quiet(input string req);
    chk(req, "lo_oe", 32'(lo_oe), 0);
    chk(req, "hi_oe", 32'(hi_oe), 0);
    chk(req, "mem_we", 32'(mem_we), 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] rcodes [5];
    logic [7:0] b;
    void'($urandom(32'd1234));
    rcodes[0] = 4'b1100; rcodes[1] = 4'b1101; rcodes[2] = 4'b1111;
    rcodes[3] = 4'b0000; rcodes[4] = 4'b1110;

    settle(3);
    chk("reset", "address", 32'(mem_addr), 0);
    check_quiet("reset");
    rst_n = 1'b1;
    settle(2);

    // R1: no activity with flags low
    set_mode(4'b1100);
    check_quiet("R1");
    @(negedge clk); hv_prog = 1'b1; hv_core = 1'b1;
    set_mode(4'b1101);

    // R2: clear, then R4 verify at 0
    set_mode(4'b0101);
    chk("R2", "address after clear", 32'(mem_addr), 0);
    set_mode(4'b1100);
    check_verify("R4");

    // R3: three edges hold, fourth steps
    pulses(3);
    chk("R3", "address after 3 edges", 32'(mem_addr), 0);
    pulses(1);
    chk("R3", "address after 4 edges", 32'(mem_addr), 1);
    check_verify("R4");

    // R2: clear realigns the pulse counter
    pulses(2);
    set_mode(4'b0101);
    set_mode(4'b1100);
    pulses(3);
    chk("R2", "aligned 3 edges", 32'(mem_addr), 0);
    pulses(1);
    chk("R2", "aligned 4th edge", 32'(mem_addr), 1);

    // R3/R7: random pulse runs under mixed modes
    for (int k = 0; k < 8; k++) begin
      set_mode(rcodes[$urandom_range(0, 4)]);
      pulses($urandom_range(0, 23));
      set_mode(4'b1100);
      check_verify("R3");
    end

    // R5: write latch on entry, hold, strobe
    @(negedge clk); lo_in = 4'h3; hi_in = 4'hC;
    set_mode(4'b1110);
    chk("R5", "mem_we", 32'(mem_we), 1);
    chk("R5", "mem_wdata", 32'(mem_wdata), 32'h C3);
    chk("R5", "ports float", 32'(lo_oe), 0);
    @(negedge clk); lo_in = 4'h0; hi_in = 4'h0;
    settle(4);
    chk("R5", "wdata held", 32'(mem_wdata), 32'h C3);
    chk("R5", "mem_we held", 32'(mem_we), 1);

    for (int k = 0; k < 4; k++) begin
      b = 8'($urandom);
      set_mode(4'b1101);
      @(negedge clk); lo_in = b[3:0]; hi_in = b[7:4];
      set_mode(4'b1110);
      chk("R5", "random wdata", 32'(mem_wdata), 32'(b));
      chk("R5", "random strobe", 32'(mem_we), 1);
    end

    // R6: inhibit with MD1 either value
    set_mode(4'b1101);
    check_quiet("R6");
    set_mode(4'b1111);
    check_quiet("R6");

    // R7: unlisted codes behave as inhibit
    set_mode(4'b0000); check_quiet("R7");
    set_mode(4'b1000); check_quiet("R7");
    set_mode(4'b0111); check_quiet("R7");
    pulses(4);
    set_mode(4'b1100);
    check_verify("R7");

    // R1: flag loss blocks drive, strobe, stepping and clear
    @(negedge clk); hv_prog = 1'b0;
    settle(4);
    check_quiet("R1");
    pulses(8);
    set_mode(4'b0101);
    @(negedge clk); hv_prog = 1'b1; hv_core = 1'b0;
    set_mode(4'b1110);
    check_quiet("R1");
    @(negedge clk); hv_core = 1'b1;
    set_mode(4'b1100);
    check_verify("R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule